// File: doc/BRIEF.md
# Hashed Page Table Walker

The walker turns a 32-bit effective address into a physical address by searching a hashed page table held in external memory. When a walk starts it samples the effective address, the segment register value chosen by the address's top nibble, and a table-base register. From these it computes two page-table-group addresses and one compare word. It then reads 64-bit table entries one at a time over a simple request/valid port and stops at the first entry whose upper word equals the compare word. The primary group is searched first. The secondary group is searched only when no entry in the primary group matches. After the search the walker resolves the access right from the matching entry, the segment key bits and the kind of access.

The caller reads the segment register named by `seg_index` and presents its value on `seg_val` in the cycle `start` is high. The table-base register holds the table origin in bits 31:16 and a 9-bit hash mask in bits 8:0. Segment value bits: 30 is the supervisor key, 29 is the user key, 28 is no-execute, and 23:0 is the virtual segment id. Page-table entry lower-word bits: 31:12 is the real page number, 3 is guarded, and 1:0 is the protection code. The access code is 0 for none, 1 for read-only and 2 for read-write.

The state machine has four states. IDLE waits for `start`. ISSUE raises `mem_req` for one cycle. WAIT holds until `mem_valid`. DONE pulses `done`. The transitions are:
- IDLE→ISSUE when `start` is high.
- ISSUE→WAIT always.
- WAIT→DONE on a matching entry, or when the eighth secondary entry misses.
- WAIT→ISSUE on any other miss. Moving on from the eighth primary entry switches to the secondary group.
- DONE→IDLE always.

Top module: `hpt_walker`

## Requirements
- R1: `seg_index` always equals effective address bits 31:28, and the segment id used by a walk is bits 23:0 of `seg_val` as sampled with `start`.
- R2: With hash h = segment id bits 18:0 XOR address bits 27:12 for the primary group, and h XOR 0x7FFFF for the secondary group, each group address is {origin[15:9], origin[8:0] OR (h[18:10] AND mask), h[9:0], 6'b0}. Both addresses are output after every walk, hit or miss.
- R3: The compare word has bit 31 set, the segment id in bits 30:7, bit 6 clear and address bits 27:22 in bits 5:0. Bit 6 is set once the secondary search begins.
- R4: The walker reads entries at group + 8·i for i = 0..7 in ascending order and keeps at most one read outstanding. The upper word of an entry is data bits 63:32. The first entry whose upper word equals the compare word ends the search.
- R5: The secondary group is read only after all eight primary entries miss. A walk issues at most 16 reads. A total miss gives hit 0 and access none.
- R6: On a hit the physical address is the entry's bits 31:12 joined with address bits 11:0.
- R7: With the key set (user key and user mode, or supervisor key and supervisor mode), protection code 0 gives none, codes 1 and 3 give read-only, and code 2 gives read-write.
- R8: With the key clear, code 3 gives read-only and every other code gives read-write. A write to a read-only page gives none.
- R9: An instruction fetch from a no-execute segment or a guarded page gives hit 1 and access none.
- R10: `start` is ignored while a walk is in progress. `done` is a one-cycle pulse. Results hold until the next accepted `start`.
- R11: After reset the walker is idle, with `mem_req` and `done` low and all result outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| eff_addr | input | 32 | Effective address to translate |
| seg_index | output | 4 | Segment register number for `eff_addr` |
| seg_val | input | 32 | Selected segment register value |
| tbl_base | input | 32 | Table origin (31:16) and hash mask (8:0) |
| is_fetch | input | 1 | Access is an instruction fetch |
| is_write | input | 1 | Access is a store |
| user_mode | input | 1 | Processor is in user mode |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_valid | input | 1 | Read data is valid |
| mem_data | input | 64 | Entry read from the table |
| done | output | 1 | Walk finished (one-cycle pulse) |
| hit | output | 1 | A matching entry was found |
| phys_addr | output | 32 | Translated physical address |
| access | output | 2 | Granted access: 0 none, 1 read-only, 2 read-write |
| grp_pri | output | 32 | Primary group address |
| grp_sec | output | 32 | Secondary group address |
| cmp_word | output | 32 | Compare word of the last search |

## Verification
On every cycle the assertions check that:
- a read is never followed at once by another read;
- every request is aligned to an entry inside one of the two groups;
- no more than 16 reads are issued per walk;
- the valid bit is set in the compare word;
- a miss never grants access;
- `done` is a pulse and results stay stable after it.

Only the bench scenarios can show which slot was taken, that a duplicate later in the group loses, that secondary decoys carrying the primary compare word are skipped, the exact group arithmetic under varied masks, the full protection truth table, and that a start pulsed mid-walk leaves the result untouched.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    localparam int EA_W      = 32;
    localparam int VSID_W    = 24;
    localparam int HASH_W    = 19;
    localparam int MASK_W    = 9;
    localparam int SEG_KS    = 30;
    localparam int SEG_KP    = 29;
    localparam int SEG_NX    = 28;
    localparam int CMP_HSEL  = 6;
    localparam int PTE_GUARD = 3;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RO   = 2'd1,
        ACC_RW   = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_st_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
    import hpt_pkg::*;
(
    input  logic [HASH_W-1:0]  vsid_lo,
    input  logic [15:0]        page_idx,
    input  logic [15:0]        origin,
    input  logic [MASK_W-1:0]  mask,
    output logic [1:0][EA_W-1:0] grp
);
    localparam logic [HASH_W-1:0] SEC_FLIP = {HASH_W{1'b1}};

    for (genvar g = 0; g < 2; g++) begin : g_hash
        logic [HASH_W-1:0] h;
        assign h = (vsid_lo ^ {{(HASH_W-16){1'b0}}, page_idx}) ^ ((g == 1) ? SEC_FLIP : '0);
        assign grp[g] = {origin[15:9], origin[8:0] | (h[18:10] & mask), h[9:0], 6'b0};
    end
endmodule

// File: rtl/hpt_prot.sv
module hpt_prot
    import hpt_pkg::*;
(
    input  logic        found,
    input  logic [31:0] pte_lo,
    input  logic        ks,
    input  logic        kp,
    input  logic        nx,
    input  logic [11:0] ea_off,
    input  logic        fetch,
    input  logic        write,
    input  logic        user,
    output logic        hit,
    output logic [31:0] phys,
    output acc_e        access
);
    logic       key;
    logic [1:0] pp;
    acc_e       grant;
    logic       unused_pte;

    assign unused_pte = ^{pte_lo[11:4], pte_lo[2]};
    assign key  = (kp & user) | (ks & ~user);
    assign pp   = pte_lo[1:0];
    assign hit  = found;
    assign phys = {pte_lo[31:12], ea_off};

    always_comb begin
        if (key) begin
            unique case (pp)
                2'd0:       grant = ACC_NONE;
                2'd2:       grant = ACC_RW;
                default:    grant = ACC_RO;
            endcase
        end else begin
            grant = (pp == 2'd3) ? ACC_RO : ACC_RW;
        end
        if (grant == ACC_RO && write)
            grant = ACC_NONE;
        if (fetch && (nx || pte_lo[PTE_GUARD]))
            grant = ACC_NONE;
        if (!found)
            grant = ACC_NONE;
        access = grant;
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int ENTRIES     = 8,
    parameter int ENTRY_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] eff_addr,
    output logic [3:0]  seg_index,
    input  logic [31:0] seg_val,
    input  logic [31:0] tbl_base,
    input  logic        is_fetch,
    input  logic        is_write,
    input  logic        user_mode,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_valid,
    input  logic [63:0] mem_data,
    output logic        done,
    output logic        hit,
    output logic [31:0] phys_addr,
    output logic [1:0]  access,
    output logic [31:0] grp_pri,
    output logic [31:0] grp_sec,
    output logic [31:0] cmp_word
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int BYTE_W = $clog2(ENTRY_BYTES);
    localparam int OFF_W  = IDX_W + BYTE_W;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ENTRIES - 1);

    walk_st_e          state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              sec_q, found_q;
    logic [31:0]       ea_q, lower_q, cmp_q, grp_pri_q, grp_sec_q;
    logic              ks_q, kp_q, nx_q, fetch_q, write_q, user_q;
    logic [1:0][31:0]  grp_calc;
    logic              entry_hit, idx_last;
    acc_e              acc_w;
    logic              unused_in;

    assign unused_in = ^{tbl_base[15:9], seg_val[31], seg_val[27:24]};
    assign seg_index = eff_addr[31:28];

    hpt_hash u_hash (
        .vsid_lo  (seg_val[HASH_W-1:0]),
        .page_idx (eff_addr[27:12]),
        .origin   (tbl_base[31:16]),
        .mask     (tbl_base[MASK_W-1:0]),
        .grp      (grp_calc)
    );

    assign entry_hit = (mem_data[63:32] == cmp_q);
    assign idx_last  = (idx_q == IDX_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_valid) begin
                    if (entry_hit || (idx_last && sec_q)) state_d = ST_DONE;
                    else                                  state_d = ST_ISSUE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0; sec_q <= 1'b0; found_q <= 1'b0;
            ea_q <= '0; lower_q <= '0; cmp_q <= '0;
            grp_pri_q <= '0; grp_sec_q <= '0;
            ks_q <= 1'b0; kp_q <= 1'b0; nx_q <= 1'b0;
            fetch_q <= 1'b0; write_q <= 1'b0; user_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    ea_q      <= eff_addr;
                    ks_q      <= seg_val[SEG_KS];
                    kp_q      <= seg_val[SEG_KP];
                    nx_q      <= seg_val[SEG_NX];
                    fetch_q   <= is_fetch;
                    write_q   <= is_write;
                    user_q    <= user_mode;
                    cmp_q     <= {1'b1, seg_val[VSID_W-1:0], 1'b0, eff_addr[27:22]};
                    grp_pri_q <= grp_calc[0];
                    grp_sec_q <= grp_calc[1];
                    idx_q     <= '0;
                    sec_q     <= 1'b0;
                    found_q   <= 1'b0;
                    lower_q   <= '0;
                end
                ST_WAIT: if (mem_valid) begin
                    if (entry_hit) begin
                        found_q <= 1'b1;
                        lower_q <= mem_data[31:0];
                    end else if (idx_last) begin
                        if (!sec_q) begin
                            sec_q           <= 1'b1;
                            idx_q           <= '0;
                            cmp_q[CMP_HSEL] <= 1'b1;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    hpt_prot u_prot (
        .found  (found_q),
        .pte_lo (lower_q),
        .ks     (ks_q),
        .kp     (kp_q),
        .nx     (nx_q),
        .ea_off (ea_q[11:0]),
        .fetch  (fetch_q),
        .write  (write_q),
        .user   (user_q),
        .hit    (hit),
        .phys   (phys_addr),
        .access (acc_w)
    );

    // outputs
    always_comb begin
        mem_req  = (state_q == ST_ISSUE);
        done     = (state_q == ST_DONE);
        mem_addr = (sec_q ? grp_sec_q : grp_pri_q)
                 | {{(32-OFF_W){1'b0}}, idx_q, {BYTE_W{1'b0}}};
        access   = acc_w;
        grp_pri  = grp_pri_q;
        grp_sec  = grp_sec_q;
        cmp_word = cmp_q;
    end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        done,
    input logic        hit,
    input logic [1:0]  access,
    input logic [31:0] phys_addr,
    input logic [31:0] grp_pri,
    input logic [31:0] grp_sec,
    input logic [31:0] cmp_word
);
    logic [4:0] rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_cnt <= '0;
        else if (done)    rd_cnt <= '0;
        else if (mem_req) rd_cnt <= rd_cnt + 5'd1;
    end

    p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_req_in_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'd0) &&
                    ((mem_addr[31:6] == grp_pri[31:6]) || (mem_addr[31:6] == grp_sec[31:6])));

    p_read_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> rd_cnt < 5'd16);

    p_miss_denied_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> access == 2'd0);

    p_cmp_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmp_word[31]);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(hit) && $stable(access) && $stable(phys_addr));
endmodule

bind hpt_walker hpt_walker_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .done      (done),
    .hit       (hit),
    .access    (access),
    .phys_addr (phys_addr),
    .grp_pri   (grp_pri),
    .grp_sec   (grp_sec),
    .cmp_word  (cmp_word)
);

// File: tb/hpt_walker_tb_top.sv
module hpt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] eff_addr = '0;
    logic [3:0]  seg_index;
    logic [31:0] seg_val = '0;
    logic [31:0] tbl_base = '0;
    logic        is_fetch = 1'b0, is_write = 1'b0, user_mode = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_data = '0;
    logic        done, hit;
    logic [31:0] phys_addr, grp_pri, grp_sec, cmp_word;
    logic [1:0]  access;

    int checks = 0;
    int errors = 0;
    int nreads = 0;
    logic        pend = 1'b0;
    logic [31:0] paddr = '0;
    int          lat = 0;
    logic [63:0] mem [int unsigned];

    always #4 clk = ~clk;

    hpt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .eff_addr(eff_addr),
        .seg_index(seg_index), .seg_val(seg_val), .tbl_base(tbl_base),
        .is_fetch(is_fetch), .is_write(is_write), .user_mode(user_mode),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_data(mem_data), .done(done), .hit(hit), .phys_addr(phys_addr),
        .access(access), .grp_pri(grp_pri), .grp_sec(grp_sec), .cmp_word(cmp_word)
    );

    function automatic logic [63:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // memory responder with varying latency
    always @(posedge clk) begin
        mem_valid <= 1'b0;
        if (pend) begin
            if (lat == 0) begin
                mem_valid <= 1'b1;
                mem_data  <= rd(paddr);
                pend      <= 1'b0;
            end else begin
                lat <= lat - 1;
            end
        end
        if (mem_req) begin
            pend   <= 1'b1;
            paddr  <= mem_addr;
            lat    <= nreads % 3;
            nreads <= nreads + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_grp(input logic [31:0] seg, input logic [31:0] ea,
                                            input logic [31:0] base, input bit sec);
        logic [18:0] h;
        h = seg[18:0] ^ {3'b0, ea[27:12]};
        if (sec) h = h ^ 19'h7FFFF;
        return {base[31:25], base[24:16] | (h[18:10] & base[8:0]), h[9:0], 6'b0};
    endfunction

    function automatic logic [1:0] exp_acc(input logic [31:0] seg, input logic [31:0] lo,
                                           input bit fetch, input bit write, input bit user);
        logic [1:0] a;
        bit key;
        key = (seg[29] && user) || (seg[30] && !user);
        if (key) a = (lo[1:0] == 2'd0) ? 2'd0 : (lo[1:0] == 2'd2) ? 2'd2 : 2'd1;
        else     a = (lo[1:0] == 2'd3) ? 2'd1 : 2'd2;
        if (a == 2'd1 && write) a = 2'd0;
        if (fetch && (seg[28] || lo[3])) a = 2'd0;
        return a;
    endfunction

    // place: 0..7 primary slot, 8..15 secondary slot, 16 miss
    task automatic walk(input logic [31:0] ea, input logic [31:0] seg, input logic [31:0] base,
                        input logic [31:0] lo, input bit fetch, input bit write, input bit user,
                        input int place, input bit poke, input string ptag);
        logic [31:0] gp, gs, cp, cs, tgt;
        logic [1:0]  ea_acc;
        int n0, exp_rd;
        bit exp_hit;
        gp = exp_grp(seg, ea, base, 1'b0);
        gs = exp_grp(seg, ea, base, 1'b1);
        cp = {1'b1, seg[23:0], 1'b0, ea[27:22]};
        cs = cp | 32'h40;
        mem.delete();
        for (int i = 0; i < 8; i++) begin
            mem[gp + 8*i] = {cs, 32'hDEAD0000};
            mem[gs + 8*i] = {cp, 32'hBEEF0000};
        end
        if (place < 16) begin
            tgt = (place < 8) ? gp + 8*place : gs + 8*(place - 8);
            mem[tgt] = {(place < 8) ? cp : cs, lo};
            if ((place % 8) < 7) mem[tgt + 8] = {(place < 8) ? cp : cs, ~lo};
        end
        @(negedge clk);
        eff_addr = ea; seg_val = seg; tbl_base = base;
        is_fetch = fetch; is_write = write; user_mode = user;
        start = 1'b1;
        n0 = nreads;
        #1;
        chk(seg_index == ea[31:28], "R1", "seg_index", {28'd0, seg_index}, {28'd0, ea[31:28]});
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            eff_addr = ~ea; seg_val = ~seg; is_write = ~write;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        exp_hit = (place < 16);
        exp_rd  = (place + 1 > 16) ? 16 : place + 1;
        ea_acc  = exp_hit ? exp_acc(seg, lo, fetch, write, user) : 2'd0;
        chk(grp_pri == gp, "R2", "grp_pri", grp_pri, gp);
        chk(grp_sec == gs, "R2", "grp_sec", grp_sec, gs);
        chk(cmp_word == ((place < 8) ? cp : cs), "R3", "cmp_word", cmp_word, (place < 8) ? cp : cs);
        chk((nreads - n0) == exp_rd, "R5", "read count", nreads - n0, exp_rd);
        chk(hit == exp_hit, "R4", "hit", {31'd0, hit}, {31'd0, exp_hit});
        if (exp_hit)
            chk(phys_addr == {lo[31:12], ea[11:0]}, "R6", "phys", phys_addr, {lo[31:12], ea[11:0]});
        chk(access == ea_acc, ptag, "access", {30'd0, access}, {30'd0, ea_acc});
        repeat (2) @(negedge clk);
        chk(hit == exp_hit && access == ea_acc, "R10", "result hold", {30'd0, access}, {30'd0, ea_acc});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!done && !mem_req, "R11", "ctrl idle", {30'd0, done, mem_req}, 32'd0);
        chk(!hit && access == 2'd0 && phys_addr == 0, "R11", "result zero", phys_addr, 32'd0);
        chk(grp_pri == 0 && grp_sec == 0 && cmp_word == 0, "R11", "addr zero", cmp_word, 32'd0);
        rst_n = 1'b1;

        // placement sweep: R2..R6, key clear RW
        for (int p = 0; p <= 16; p++) begin
            walk(32'h1234_5678 + 32'h0013_7000 * p,
                 {8'h00, 24'hA5C3F1 ^ (24'h01F0E3 * p)},
                 {16'h3C00 + 16'h0A35 * p[15:0], 7'd0, 9'h1FF >> (p % 10)},
                 32'h0ABC_D002 + (32'h1000 * p),
                 1'b0, 1'b0, 1'b0, p, 1'b0, "R8");
        end

        // protection sweep: R7 (key set) and R8 (key clear, write to RO)
        for (int k = 0; k < 4; k++)
            for (int u = 0; u < 2; u++)
                for (int pp = 0; pp < 4; pp++)
                    for (int w = 0; w < 2; w++) begin
                        logic [31:0] sg;
                        bit ky;
                        sg = {1'b0, k[1], k[0], 1'b0, 4'h0, 24'h00F00D + 24'(k*8 + pp)};
                        ky = (k[0] && u == 1) || (k[1] && u == 0);
                        walk(32'h7654_3210 ^ 32'(pp << 14), sg, 32'h0050_0003,
                             32'h1357_9000 | 32'(pp), 1'b0, w[0], u[0],
                             (pp + k) % 3, 1'b0, ky ? "R7" : "R8");
                    end

        // fetch: no-execute segment and guarded page (R9)
        for (int f = 0; f < 8; f++) begin
            walk(32'h0040_1ABC + 32'(f << 12), {3'b0, f[0], 4'h0, 24'h123456},
                 32'h00A0_0000, 32'h2468_A002 | 32'(f[1] << 3), 1'b1, 1'b0, f[2],
                 f % 2 + 9, 1'b0, "R9");
        end

        // start pulsed while busy must be ignored (R10)
        walk(32'hCAFE_B123, {8'h00, 24'h654321}, 32'h0100_00FF, 32'h0FED_C001,
             1'b0, 1'b1, 1'b0, 12, 1'b1, "R10");
        walk(32'h0BAD_F00D, {8'h40, 24'h0A0B0C}, 32'h0200_01F0, 32'h0AAA_A002,
             1'b0, 1'b0, 1'b0, 16, 1'b1, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule